// File: doc/BRIEF.md
# Loadable Up/Down Counter with Limit Flag

This block is a synchronous binary counter whose width is set by a parameter (four bits by default). A direction input picks counting upwards or downwards, and a parallel value can be written into the count at any time. A separate limit input is compared for equality with the present count. The result is a flag that a neighbouring block can use to end a count window, divide a rate, or feed back into the load input for modulo-N counting.

Each clock, a priority decoder picks one of five actions for the count register. CLEAR is taken when reset is high. LOAD is taken when load is high and reset is low. UP is taken when enable is high, load is low and direction is up. DOWN is the same case with direction down. HOLD is taken in every other case. The action is combinational, and the count register moves from its present value to the value that action gives on each rising edge. Every action can follow every other action. The decoded inputs of the present cycle alone select the transition. The limit flag does not use the clock: it is high in the same cycle in which the count equals the limit.

Top module: `updown_limit_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` is zero after that edge.
- R2: Reset takes priority: with `rst` high, `ld` and `en` have no effect on the value held after the edge.
- R3: With `rst` low and `ld` high, `count` takes `ld_val` at the next edge, whatever `en` and `dir_up` are, so a load also works while `en` is low.
- R4: With `rst` low, `ld` low, `en` high and `dir_up` = 1, `count` increases by one per edge.
- R5: With `rst` low, `ld` low, `en` high and `dir_up` = 0, `count` decreases by one per edge.
- R6: With `rst`, `ld` and `en` all low, `count` keeps its value whatever `dir_up` is.
- R7: `at_limit` is 1 exactly when every bit of `count` equals the same bit of `lim`. It is valid in the same cycle, without any register delay.
- R8: Counting wraps modulo 2^CNT_W: counting up from all ones gives zero, and counting down from zero gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| ld | input | 1 | Parallel load request; works even while `en` is low |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| ld_val | input | CNT_W | Value written into the count on a load |
| lim | input | CNT_W | Limit that `count` is compared against |
| count | output | CNT_W | Present count |
| at_limit | output | 1 | High while `count` equals `lim` |

## Verification
The count register is the only state in the block. A wrong next-state choice therefore shows up on `count` one edge after the stimulus that caused it. The same error shows up on `at_limit` in that same cycle whenever the bench keeps the limit equal to the value the model expects. The bench compares both outputs with a behavioural model after every edge. It runs long up and down runs across the wrap points. It also drives loads with enable low, reset at the same time as load and enable, holds with the direction toggling, and limit values that match and just miss the count. Because of this, a wrong toggle term in the carry chain, a swapped priority or a slip in the compare is reported within one cycle of the case that exposes it.

// File: rtl/updown_limit_counter_pkg.sv
package updown_limit_counter_pkg;

    // Action the count register takes at the next rising edge.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_UP    = 3'd3,
        ACT_DOWN  = 3'd4
    } cnt_action_t;

endpackage

// File: rtl/ulc_action_decode.sv
module ulc_action_decode
    import updown_limit_counter_pkg::*;
(
    input  logic        rst,
    input  logic        ld,
    input  logic        en,
    input  logic        dir_up,
    output cnt_action_t action
);

    // Priority: clear, then load, then count, else hold.
    always_comb begin
        if (rst) begin
            action = ACT_CLEAR;
        end else if (ld) begin
            action = ACT_LOAD;
        end else if (en) begin
            action = dir_up ? ACT_UP : ACT_DOWN;
        end else begin
            action = ACT_HOLD;
        end
    end

    // R2: while reset is asserted no other action may be chosen
    always_comb begin
        if (rst) begin
            a_r2_reset_wins : assert (action == ACT_CLEAR);
        end
    end

endmodule

// File: rtl/ulc_step.sv
module ulc_step #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] nxt_up,
    output logic [CNT_W-1:0] nxt_dn
);

    // Toggle enables: bit i flips upward when all lower bits are one,
    // downward when all lower bits are zero.
    logic [CNT_W-1:0] tog_up;
    logic [CNT_W-1:0] tog_dn;

    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign tog_up[i] = 1'b1;
            assign tog_dn[i] = 1'b1;
        end else begin : g_upper
            assign tog_up[i] = tog_up[i-1] &  cur[i-1];
            assign tog_dn[i] = tog_dn[i-1] & ~cur[i-1];
        end
    end

    assign nxt_up = cur ^ tog_up;
    assign nxt_dn = cur ^ tog_dn;

    // R4 / R5 / R8: toggle chains agree with modular arithmetic
    always_comb begin
        a_r4_up_step   : assert (nxt_up == CNT_W'(cur + 1'b1));
        a_r5_down_step : assert (nxt_dn == CNT_W'(cur - 1'b1));
    end

endmodule

// File: rtl/ulc_limit_match.sv
module ulc_limit_match #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);

    logic [CNT_W-1:0] same;

    for (genvar i = 0; i < CNT_W; i++) begin : g_eq
        assign same[i] = ~(cnt[i] ^ lim[i]);
    end

    assign hit = &same;

endmodule

// File: rtl/updown_limit_counter.sv
module updown_limit_counter
    import updown_limit_counter_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    cnt_action_t      action;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_up;
    logic [CNT_W-1:0] cnt_dn;
    logic [CNT_W-1:0] cnt_d;

    ulc_action_decode u_decode (
        .rst    (rst),
        .ld     (ld),
        .en     (en),
        .dir_up (dir_up),
        .action (action)
    );

    ulc_step #(.CNT_W(CNT_W)) u_step (
        .cur    (cnt_q),
        .nxt_up (cnt_up),
        .nxt_dn (cnt_dn)
    );

    ulc_limit_match #(.CNT_W(CNT_W)) u_match (
        .cnt (cnt_q),
        .lim (lim),
        .hit (at_limit)
    );

    // Next-value selection, one branch per action.
    always_comb begin
        unique case (action)
            ACT_CLEAR: cnt_d = '0;
            ACT_LOAD:  cnt_d = ld_val;
            ACT_UP:    cnt_d = cnt_up;
            ACT_DOWN:  cnt_d = cnt_dn;
            ACT_HOLD:  cnt_d = cnt_q;
            default:   cnt_d = cnt_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R1 / R2: reset clears regardless of load and enable
    a_r1_reset_clears : assert property (@(posedge clk)
        rst |=> (count == '0));

    // R3: load captures the value, even with enable low
    a_r3_load_value : assert property (@(posedge clk) disable iff (rst)
        ld |=> (count == $past(ld_val)));

    // R6: idle keeps the value
    a_r6_hold : assert property (@(posedge clk) disable iff (rst)
        (!ld && !en) |=> $stable(count));

    // R8: wrap points in both directions
    a_r8_wrap_up : assert property (@(posedge clk) disable iff (rst)
        (!ld && en && dir_up && count == ALL_ONES) |=> (count == '0));
    a_r8_wrap_down : assert property (@(posedge clk) disable iff (rst)
        (!ld && en && !dir_up && count == '0) |=> (count == ALL_ONES));

    // R7: flag is same-cycle equality
    a_r7_limit_flag : assert property (@(posedge clk) disable iff (rst)
        at_limit == (count == lim));

endmodule

// File: tb/updown_limit_counter_tb_top.sv
module updown_limit_counter_tb_top;

    localparam int W    = 4;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         ld = 1'b0;
    logic         dir_up = 1'b1;
    logic [W-1:0] ld_val = '0;
    logic [W-1:0] lim = '0;
    logic [W-1:0] count;
    logic         at_limit;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    updown_limit_counter #(.CNT_W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ld       (ld),
        .dir_up   (dir_up),
        .ld_val   (ld_val),
        .lim      (lim),
        .count    (count),
        .at_limit (at_limit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle (called at a falling edge), then check at the next falling edge.
    task automatic cyc(input bit r, input bit e, input bit l, input bit u,
                       input int v, input int lm);
        string req;
        rst = r; en = e; ld = l; dir_up = u;
        ld_val = W'(v); lim = W'(lm);
        if (r) begin
            model = 0;
            req = (l || e) ? "R2" : "R1";
        end else if (l) begin
            model = v % MODV;
            req = "R3";
        end else if (e && u) begin
            req = (model == MODV - 1) ? "R8" : "R4";
            model = (model + 1) % MODV;
        end else if (e) begin
            req = (model == 0) ? "R8" : "R5";
            model = (model + MODV - 1) % MODV;
        end else begin
            req = "R6";
        end
        @(negedge clk);
        check(req, int'(count), model);
        check("R7", int'(at_limit), (model == (lm % MODV)) ? 1 : 0);
    endtask

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, 1, 0, 0);            // R1 reset state, flag matches limit 0
        cyc(0, 0, 1, 1, 9, 9);            // R3 load with enable low
        cyc(0, 0, 0, 0, 3, 9);            // R6 hold, direction down
        cyc(0, 0, 0, 1, 3, 8);            // R6 hold, flag off near miss
        cyc(1, 1, 1, 1, 7, 0);            // R2 reset beats load and enable
        cyc(0, 1, 1, 0, 14, 14);          // R3 load beats counting
        for (int i = 0; i < 20; i++)      // R4 / R8 up across wrap
            cyc(0, 1, 0, 1, 0, (i * 3) % MODV);
        for (int i = 0; i < 20; i++)      // R5 / R8 down across wrap
            cyc(0, 1, 0, 0, 0, (model + MODV - 1) % MODV);
        cyc(0, 0, 1, 0, 0, 15);           // R3 load zero
        cyc(0, 1, 0, 0, 0, 15);           // R8 zero -> all ones, R7 hit
        cyc(0, 1, 0, 1, 0, 0);            // R8 all ones -> zero, R7 hit
        for (int i = 0; i < 24; i++)      // mixed pattern
            cyc(0, (i % 3) != 0, (i % 7) == 5, (i % 2) == 0, (i * 5) % MODV, i % MODV);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule